// File: doc/BRIEF.md
# Selector Channel Output Byte Path

This block is the output data path of a selector channel that moves one block of data from memory to a single device. Memory supplies 16-bit halfwords. The device takes one byte per request. A five-slot shift buffer sits between the two sides. The memory side fills the buffer two bytes at a time while the device drains it from the head, and both can happen in the same cycle, so the full memory rate can be sustained.

A `start` pulse loads the byte count of the command. Each halfword load reduces the load count by the number of bytes it places. The final byte of the block receives an end mark, and that mark travels through the buffer with its byte. The block watches the device against the mark. It reports an exact-length transfer, an overrun (a request after the marked byte) or a short transfer (device end before the marked byte). With the status it reports the number of bytes the device never took.

Top module: `sc_out_path`

## Requirements
- R1: While `rst_n` is low and after it is released, `done`, `mem_ready` and `dev_ack` are low until a `start` pulse arrives, even while `dev_req` is high.
- R2: After `start` with count N, bytes reach `dev_data` in memory order. Bits [7:0] of each accepted halfword come out before bits [15:8]. Exactly ceil(N/2) halfwords are accepted.
- R3: The buffer never holds more than five bytes. `mem_ready` is high only while bytes remain to be loaded and at least two slots are free (occupancy three or less). With no device requests, exactly two halfwords are taken.
- R4: For an odd N, the last accepted halfword supplies only its low byte. That byte carries the end mark, and no further halfword is accepted.
- R5: `dev_ack` rises in the same cycle as `dev_req` only when a byte is held, a transfer is running and `dev_end` is low. Otherwise the request stalls with no ack and no status change.
- R6: With memory always valid and `dev_req` held high, N bytes are delivered in at most N+1 cycles counted from the cycle after the `start` cycle.
- R7: `dev_end` after the marked byte has been delivered sets `done` with `stat` = 2'b01 (exact) and `residual` = 0.
- R8: `dev_req` after the marked byte has been delivered gets no ack. It sets `done` with `stat` = 2'b10 (overrun) and `residual` = 0.
- R9: `dev_end` before the marked byte has been delivered sets `done` with `stat` = 2'b11 (short) and `residual` = N minus the bytes delivered.
- R10: With N = 0, no halfword is accepted and the transfer counts as already complete. `dev_end` then reports exact, and `dev_req` reports overrun.
- R11: `done`, `stat` and `residual` hold until the next `start`, which clears `done` one cycle later. While `done` is high, `dev_req` gets no ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transfer using `cmd_count` |
| cmd_count | input | CNT_W (16) | Bytes commanded for the block |
| mem_valid | input | 1 | Memory halfword present |
| mem_data | input | 2*8 | Halfword; low byte goes out first |
| mem_ready | output | 1 | Halfword accepted when high with `mem_valid` |
| dev_req | input | 1 | Device asks for one byte |
| dev_end | input | 1 | Device signals it has finished |
| dev_ack | output | 1 | Byte on `dev_data` is taken this cycle |
| dev_data | output | 8 | Byte at the buffer head |
| done | output | 1 | Transfer finished; status valid |
| stat | output | 2 | 01 exact, 10 overrun, 11 short |
| residual | output | CNT_W (16) | Bytes not taken by the device |

## Verification
The bench uses the default parameters: five slots, two lanes and a 16-bit count. With these values, a buffer that is full and stalled on backpressure, an odd-length tail and a zero-length command can all be reached with block sizes of twenty bytes or fewer. The default occupancy limit of three makes the alternating two-byte fill pattern visible under continuous draining. The throughput bound can therefore be checked against a cycle count.

// File: rtl/sc_pkg.sv
// Shared types for the selector channel output byte path.
// Assumes byte-wide device transfers; the slot carries one end mark bit.
package sc_pkg;
    parameter int SC_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_NONE  = 2'b00,
        ST_EXACT = 2'b01,
        ST_OVER  = 2'b10,
        ST_SHORT = 2'b11
    } sc_stat_e;

    typedef struct packed {
        logic                 last;
        logic [SC_BYTE_W-1:0] data;
    } sc_slot_t;
endpackage

// File: rtl/sc_shift_buf.sv
// Byte shift buffer: slot 0 is the head seen by the device. A pop shifts
// every slot one place toward the head; pushed bytes land just behind the
// last occupied slot after the pop. Assumes the writer never pushes past
// DEPTH (the fill controller guarantees room).
module sc_shift_buf
    import sc_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LANES = 2,
    localparam int OW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  pop,
    input  logic [NW-1:0]         push_n,
    input  sc_slot_t [LANES-1:0]  push_slot,
    output sc_slot_t              head,
    output logic [OW-1:0]         occ
);
    sc_slot_t [DEPTH-1:0] slot_q;
    sc_slot_t [DEPTH-1:0] slot_d;
    logic [OW-1:0]        base;
    logic [OW-1:0]        occ_d;

    // Next slot contents: shift on pop, then append pushed lanes.
    always_comb begin
        slot_d = slot_q;
        base   = occ;
        if (pop && occ != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                slot_d[i] = slot_q[i+1];
            end
            slot_d[DEPTH-1] = '0;
            base = occ - 1'b1;
        end
        for (int j = 0; j < LANES; j++) begin
            if (j < int'(push_n) && int'(base) + j < DEPTH) begin
                slot_d[base + OW'(j)] = push_slot[j];
            end
        end
        occ_d = base + OW'(push_n);
        if (flush) begin
            slot_d = '0;
            occ_d  = '0;
        end
    end

    // Register the slots and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            occ    <= '0;
        end else begin
            slot_q <= slot_d;
            occ    <= occ_d;
        end
    end

    assign head = slot_q[0];
endmodule

// File: rtl/sc_fill_ctrl.sv
// Memory-side fill control. Holds the count of bytes still to be loaded,
// accepts one halfword of LANES bytes when room allows, and marks the
// final byte of the block (lane 0 for an odd tail). Assumes occupancy is
// the buffer's registered value for the current cycle.
module sc_fill_ctrl
    import sc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 5,
    parameter int LANES = 2,
    localparam int OW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1),
    localparam int HW = LANES * SC_BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     cmd_count,
    input  logic                 active,
    input  logic                 mem_valid,
    input  logic [HW-1:0]        mem_data,
    input  logic [OW-1:0]        occ,
    output logic                 mem_ready,
    output logic [NW-1:0]        push_n,
    output sc_slot_t [LANES-1:0] push_slot
);
    logic [CNT_W-1:0] left_q;
    logic             tail;
    logic [NW-1:0]    take;
    logic             accept;

    // Decide whether a halfword can be taken and how many bytes it gives.
    always_comb begin
        tail      = left_q <= CNT_W'(LANES);
        take      = tail ? NW'(left_q) : NW'(LANES);
        mem_ready = active && !start && left_q != '0 && occ <= OW'(DEPTH - LANES);
        accept    = mem_ready && mem_valid;
        push_n    = accept ? take : '0;
    end

    // Split the halfword into lanes and mark the final byte.
    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            push_slot[g].data = mem_data[g*SC_BYTE_W +: SC_BYTE_W];
            push_slot[g].last = tail && (left_q == CNT_W'(g + 1));
        end
    end

    // Track bytes still to be loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= cmd_count;
        end else if (accept) begin
            left_q <= left_q - CNT_W'(take);
        end
    end
endmodule

// File: rtl/sc_end_track.sv
// Device-side handshake and end-of-block checking. Grants a request when
// the head slot holds a byte, counts bytes still owed to the device, and
// on device end or an extra request records exact, overrun or short with
// the residual count. Assumes head_last marks the block's final byte.
module sc_end_track
    import sc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             dev_req,
    input  logic             dev_end,
    input  logic             head_valid,
    input  logic             head_last,
    output logic             active,
    output logic             dev_ack,
    output logic             done,
    output logic [1:0]       stat,
    output logic [CNT_W-1:0] residual
);
    logic             run_q;
    logic             sent_q;
    logic [CNT_W-1:0] owed_q;
    sc_stat_e         stat_q;

    // Grant a byte only while running, before the marked byte has gone.
    assign dev_ack = run_q && !start && !sent_q && !dev_end && dev_req && head_valid;
    assign active  = run_q;
    assign stat    = stat_q;

    // Transfer state, owed count and final status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            sent_q   <= 1'b0;
            owed_q   <= '0;
            done     <= 1'b0;
            stat_q   <= ST_NONE;
            residual <= '0;
        end else if (start) begin
            run_q    <= 1'b1;
            sent_q   <= (cmd_count == '0);
            owed_q   <= cmd_count;
            done     <= 1'b0;
            stat_q   <= ST_NONE;
            residual <= '0;
        end else if (run_q) begin
            if (dev_end) begin
                run_q    <= 1'b0;
                done     <= 1'b1;
                stat_q   <= sent_q ? ST_EXACT : ST_SHORT;
                residual <= sent_q ? '0 : owed_q;
            end else if (dev_req && sent_q) begin
                run_q    <= 1'b0;
                done     <= 1'b1;
                stat_q   <= ST_OVER;
                residual <= '0;
            end else if (dev_ack) begin
                owed_q <= owed_q - 1'b1;
                if (head_last) begin
                    sent_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sc_out_path.sv
// Top of the selector channel output byte path: memory halfwords fill a
// shift buffer, the device drains one byte per request, and an end mark
// riding with the final byte lets the block judge the transfer length.
// Assumes one transfer at a time; a new start abandons any current one.
module sc_out_path
    import sc_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int LANES = 2,
    parameter int CNT_W = 16,
    localparam int OW = $clog2(DEPTH + 1),
    localparam int NW = $clog2(LANES + 1),
    localparam int HW = LANES * SC_BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     cmd_count,
    input  logic                 mem_valid,
    input  logic [HW-1:0]        mem_data,
    output logic                 mem_ready,
    input  logic                 dev_req,
    input  logic                 dev_end,
    output logic                 dev_ack,
    output logic [SC_BYTE_W-1:0] dev_data,
    output logic                 done,
    output logic [1:0]           stat,
    output logic [CNT_W-1:0]     residual
);
    logic                 active;
    logic [OW-1:0]        occ;
    logic [NW-1:0]        push_n;
    sc_slot_t [LANES-1:0] push_slot;
    sc_slot_t             head;

    sc_fill_ctrl #(.CNT_W(CNT_W), .DEPTH(DEPTH), .LANES(LANES)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_count (cmd_count),
        .active    (active),
        .mem_valid (mem_valid),
        .mem_data  (mem_data),
        .occ       (occ),
        .mem_ready (mem_ready),
        .push_n    (push_n),
        .push_slot (push_slot)
    );

    sc_shift_buf #(.DEPTH(DEPTH), .LANES(LANES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .pop       (dev_ack),
        .push_n    (push_n),
        .push_slot (push_slot),
        .head      (head),
        .occ       (occ)
    );

    sc_end_track #(.CNT_W(CNT_W)) u_end (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_count  (cmd_count),
        .dev_req    (dev_req),
        .dev_end    (dev_end),
        .head_valid (occ != '0),
        .head_last  (head.last),
        .active     (active),
        .dev_ack    (dev_ack),
        .done       (done),
        .stat       (stat),
        .residual   (residual)
    );

    assign dev_data = head.data;
endmodule

// File: rtl/sc_out_path_chk.sv
// Property checker for sc_out_path, bound to every instance below.
module sc_out_path_chk #(
    parameter int DEPTH = 5,
    parameter int LANES = 2,
    parameter int CNT_W = 16,
    localparam int OW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             dev_req,
    input logic             dev_end,
    input logic             dev_ack,
    input logic             mem_ready,
    input logic             done,
    input logic [1:0]       stat,
    input logic [CNT_W-1:0] residual,
    input logic [OW-1:0]    occ
);
    a_r3_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    a_r3_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> occ <= OW'(DEPTH - LANES));

    a_r5_ack_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> occ != '0);

    a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> dev_req && !dev_end);

    a_r7_exact_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat == 2'b01) |-> residual == '0);

    a_r8_over_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat == 2'b10) |-> residual == '0);

    a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(stat) && $stable(residual));

    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    a_r11_no_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dev_ack);
endmodule

bind sc_out_path sc_out_path_chk #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dev_req   (dev_req),
    .dev_end   (dev_end),
    .dev_ack   (dev_ack),
    .mem_ready (mem_ready),
    .done      (done),
    .stat      (stat),
    .residual  (residual),
    .occ       (occ)
);

// File: tb/sc_out_path_test.sv
`timescale 1ns/100ps
module sc_out_path_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmd_count = '0;
    logic        mem_valid;
    logic [15:0] mem_data;
    logic        mem_ready;
    logic        dev_req = 1'b0;
    logic        dev_end = 1'b0;
    logic        dev_ack;
    logic [7:0]  dev_data;
    logic        done;
    logic [1:0]  stat;
    logic [15:0] residual;

    int total = 0;
    int bad = 0;
    int acks = 0;
    int ptr = 0;
    logic       mem_en = 1'b1;
    logic [7:0] seed = 8'd0;
    logic [7:0] expq[$];

    always #2 clk = ~clk;

    sc_out_path uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_count(cmd_count),
        .mem_valid(mem_valid), .mem_data(mem_data), .mem_ready(mem_ready),
        .dev_req(dev_req), .dev_end(dev_end), .dev_ack(dev_ack),
        .dev_data(dev_data), .done(done), .stat(stat), .residual(residual)
    );

    function automatic logic [7:0] pat(int k);
        return 8'(k * 7 + int'(seed) + 1);
    endfunction

    // Memory model: next halfword of the pattern, advanced on acceptance.
    assign mem_valid = mem_en;
    assign mem_data  = {pat(ptr + 1), pat(ptr)};
    always @(posedge clk) if (mem_valid && mem_ready) ptr <= ptr + 2;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each delivered byte against the scoreboard queue.
    always begin
        @(negedge clk);
        #1;
        if (dev_req && dev_ack) begin
            acks++;
            if (expq.size() == 0) chk("R5 ack with nothing expected", 1, 0);
            else chk("R2 byte order", dev_data, expq.pop_front());
        end
    end

    // Driver: launch a block and queue its expected bytes.
    task automatic do_start(int n, logic [7:0] s);
        @(negedge clk);
        seed = s;
        ptr = 0;
        expq.delete();
        for (int k = 0; k < n; k++) expq.push_back(pat(k));
        cmd_count = 16'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic take(int n, output int cyc);
        int target;
        target = acks + n;
        cyc = 0;
        while (acks < target && cyc < 200) begin
            @(negedge clk);
            dev_req = 1'b1;
            #1.5;
            cyc++;
        end
        @(negedge clk);
        dev_req = 1'b0;
    endtask

    task automatic end_pulse();
        @(negedge clk);
        dev_end = 1'b1;
        @(negedge clk);
        dev_end = 1'b0;
        #1.5;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1.5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        // R1: reset state, with a request pending.
        repeat (3) @(negedge clk);
        dev_req = 1'b1;
        #1.5;
        chk("R1 done in reset", done, 0);
        chk("R1 ready in reset", mem_ready, 0);
        chk("R1 ack in reset", dev_ack, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1.5;
        chk("R1 ack after reset", dev_ack, 0);
        chk("R1 ready after reset", mem_ready, 0);
        @(negedge clk);
        dev_req = 1'b0;

        // R2 and R7: even block, exact length.
        do_start(10, 8'h03);
        take(10, cyc);
        chk("R2 halfwords taken", ptr, 10);
        chk("R2 all bytes out", expq.size(), 0);
        end_pulse();
        chk("R7 done", done, 1);
        chk("R7 stat exact", stat, 2'b01);
        chk("R7 residual", residual, 0);

        // R4: odd block, one-byte tail.
        do_start(7, 8'h40);
        take(7, cyc);
        idle(3);
        chk("R4 halfwords taken", ptr, 8);
        chk("R4 all bytes out", expq.size(), 0);
        end_pulse();
        chk("R4 stat exact", stat, 2'b01);

        // R8: request after the marked byte.
        do_start(4, 8'h11);
        take(4, cyc);
        @(negedge clk);
        dev_req = 1'b1;
        #1.5;
        chk("R8 no ack on overrun", dev_ack, 0);
        @(negedge clk);
        dev_req = 1'b0;
        #1.5;
        chk("R8 done", done, 1);
        chk("R8 stat overrun", stat, 2'b10);
        chk("R8 residual", residual, 0);

        // R9 and R11: device ends early; status then holds.
        do_start(12, 8'h77);
        take(5, cyc);
        end_pulse();
        chk("R9 done", done, 1);
        chk("R9 stat short", stat, 2'b11);
        chk("R9 residual", residual, 7);
        @(negedge clk);
        dev_req = 1'b1;
        #1.5;
        chk("R11 no ack while done", dev_ack, 0);
        @(negedge clk);
        dev_req = 1'b0;
        #1.5;
        chk("R11 done holds", done, 1);
        chk("R11 stat holds", stat, 2'b11);
        chk("R11 residual holds", residual, 7);

        // R5: requests stall while the buffer is empty.
        mem_en = 1'b0;
        do_start(3, 8'h22);
        chk("R11 start clears done", done, 0);
        @(negedge clk);
        dev_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1.5;
            chk("R5 stall no ack", dev_ack, 0);
            chk("R5 stall no done", done, 0);
            @(negedge clk);
        end
        dev_req = 1'b0;
        mem_en = 1'b1;
        take(3, cyc);
        end_pulse();
        chk("R5 stall then exact", stat, 2'b01);
        chk("R5 all bytes out", expq.size(), 0);

        // R10: zero-length block, exact then overrun.
        do_start(0, 8'h00);
        idle(3);
        chk("R10 no halfword", ptr, 0);
        end_pulse();
        chk("R10 zero exact", stat, 2'b01);
        chk("R10 zero residual", residual, 0);
        do_start(0, 8'h00);
        @(negedge clk);
        dev_req = 1'b1;
        #1.5;
        chk("R10 zero no ack", dev_ack, 0);
        @(negedge clk);
        dev_req = 1'b0;
        #1.5;
        chk("R10 zero overrun", stat, 2'b10);

        // R3: no requests, buffer fills to its limit and stops.
        do_start(20, 8'h5a);
        idle(8);
        chk("R3 halfwords while full", ptr, 4);
        chk("R3 ready low while full", mem_ready, 0);
        take(20, cyc);
        end_pulse();
        chk("R3 then exact", stat, 2'b01);

        // R6: continuous draining at one byte per cycle.
        do_start(20, 8'h99);
        take(20, cyc);
        chk("R6 cycles within bound", 32'(cyc <= 21), 1);
        chk("R6 all bytes out", expq.size(), 0);
        end_pulse();
        chk("R6 stat exact", stat, 2'b01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule